// File: doc/BRIEF.md
# CTC Greedy Label Decoder

This block turns the per-column scores of a connectionist temporal classification output layer into a stream of recognised characters. For each image column (one timestep), the scores of all `NUM_CLASSES` output units arrive one per cycle. The block keeps a running maximum and, on the score flagged as last of the column, settles on the most likely unit. The highest-numbered unit stands for "no character". Softmax is monotonic, so taking the largest raw score gives the same winner as taking the largest probability, and no normalisation is needed.

Column decisions are then collapsed into characters without any pre-segmentation. A decision that repeats the previous column's character is dropped. A blank decision emits nothing and breaks the repeat chain. An end-of-line input clears the chain and produces a one-cycle done pulse that stays in order with the character stream.

Top module: `ctc_greedy_decoder`

## Requirements
- R1: After reset, `out_valid` and `line_done` are low until a column or an end-of-line has been processed.
- R2: The decision for a column is the position (0 for the first score after the previous `score_last`) of its largest score, compared as signed two's complement values.
- R3: When several positions share the largest score, the lowest position is the decision.
- R4: Position `NUM_CLASSES-1` is the blank; a blank decision never raises `out_valid`.
- R5: A non-blank decision equal to the previous column's decision raises no `out_valid`.
- R6: After a blank column, a non-blank decision is emitted even if it equals the character before the blank.
- R7: The first column after reset or after an end-of-line is emitted whenever its decision is non-blank.
- R8: `line_end` high in a cycle makes `line_done` high for one cycle two clock edges later and clears the repeat state. A column ending in the same cycle is first judged against the old state.
- R9: For an emitted column, `out_valid` is high for exactly one cycle, two clock edges after the cycle carrying `score_last`, with `out_label` holding the decision.
- R10: Cycles with `score_valid` low do not advance the position count and their `score` value has no effect on the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| score_valid | input | 1 | `score` carries the next output-unit score |
| score | input | SCORE_W | Signed score of the current unit |
| score_last | input | 1 | Qualified by `score_valid`: this is the last unit of the column |
| line_end | input | 1 | End of the text line; clears repeat state |
| out_valid | output | 1 | One-cycle strobe for an emitted character |
| out_label | output | $clog2(NUM_CLASSES) | Emitted character index |
| line_done | output | 1 | One-cycle end-of-line acknowledgement |

## Verification
The bench runs a four-class configuration and goes after equal scores across several positions. A design that scans with `>=` would report the highest tied index instead of the lowest. It also covers all-negative columns, where a maximum that starts from zero rather than from the first score would pick the wrong unit. Repeat and blank sequences are checked as well: a design that forgets to clear the chain on a blank would swallow a legitimately doubled letter, and one that never remembers the chain would stutter. End-of-line coinciding with a column's last score and idle cycles carrying large scores inside a column are both driven. A design that clears state too early, or that lets idle data into the comparison, would emit the wrong characters.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
   // Width of a class index; at least one bit.
   function automatic int idx_width(input int classes);
      return (classes > 1) ? $clog2(classes) : 1;
   endfunction
endpackage

// File: rtl/ctc_col_argmax.sv
module ctc_col_argmax #(
   parameter int NUM_CLASSES = 110,
   parameter int SCORE_W     = 16,
   parameter int IDX_W       = ctc_pkg::idx_width(NUM_CLASSES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic signed [SCORE_W-1:0] in_score,
   input  logic                      in_last,
   input  logic                      in_eol,
   output logic                      dec_valid,
   output logic [IDX_W-1:0]          dec_idx,
   output logic                      dec_eol
);
   logic [IDX_W-1:0]          pos_q;
   logic [IDX_W-1:0]          best_idx_q;
   logic signed [SCORE_W-1:0] best_q;
   logic                      have_q;
   logic                      take;
   logic [IDX_W-1:0]          cand_idx;

   // strictly greater: an equal later score never displaces an earlier one
   always_comb begin
      take     = in_valid && (!have_q || (in_score > best_q));
      cand_idx = take ? pos_q : best_idx_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q      <= '0;
         best_idx_q <= '0;
         best_q     <= '0;
         have_q     <= 1'b0;
         dec_valid  <= 1'b0;
         dec_idx    <= '0;
         dec_eol    <= 1'b0;
      end else begin
         dec_valid <= in_valid && in_last;
         dec_eol   <= in_eol;
         if (in_valid && in_last) begin
            dec_idx <= cand_idx;
         end
         if (in_valid) begin
            if (in_last) begin
               pos_q  <= '0;
               have_q <= 1'b0;
            end else begin
               pos_q  <= pos_q + 1'b1;
               have_q <= 1'b1;
               if (take) begin
                  best_q     <= in_score;
                  best_idx_q <= pos_q;
               end
            end
         end
      end
   end
endmodule

// File: rtl/ctc_collapse.sv
module ctc_collapse #(
   parameter int NUM_CLASSES = 110,
   parameter int IDX_W       = ctc_pkg::idx_width(NUM_CLASSES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dec_valid,
   input  logic [IDX_W-1:0] dec_idx,
   input  logic             dec_eol,
   output logic             out_valid,
   output logic [IDX_W-1:0] out_label,
   output logic             line_done
);
   localparam logic [IDX_W-1:0] BLANK_IDX = IDX_W'(NUM_CLASSES - 1);

   logic             prev_live_q;
   logic [IDX_W-1:0] prev_idx_q;
   logic             is_blank;
   logic             emit;

   always_comb begin
      is_blank = (dec_idx == BLANK_IDX);
      emit     = dec_valid && !is_blank && !(prev_live_q && (prev_idx_q == dec_idx));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_live_q <= 1'b0;
         prev_idx_q  <= '0;
         out_valid   <= 1'b0;
         out_label   <= '0;
         line_done   <= 1'b0;
      end else begin
         out_valid <= emit;
         line_done <= dec_eol;
         if (emit) begin
            out_label <= dec_idx;
         end
         // column is judged first; end-of-line then wipes the chain
         if (dec_eol) begin
            prev_live_q <= 1'b0;
         end else if (dec_valid) begin
            prev_live_q <= !is_blank;
            prev_idx_q  <= dec_idx;
         end
      end
   end
endmodule

// File: rtl/ctc_greedy_decoder.sv
module ctc_greedy_decoder #(
   parameter int NUM_CLASSES = 110,
   parameter int SCORE_W     = 16,
   localparam int IDX_W      = ctc_pkg::idx_width(NUM_CLASSES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      score_valid,
   input  logic signed [SCORE_W-1:0] score,
   input  logic                      score_last,
   input  logic                      line_end,
   output logic                      out_valid,
   output logic [IDX_W-1:0]          out_label,
   output logic                      line_done
);
   generate
      if (NUM_CLASSES < 2) begin : g_bad_classes
         $error("NUM_CLASSES must be at least 2 (one label plus blank)");
      end
      if (SCORE_W < 2) begin : g_bad_width
         $error("SCORE_W must be at least 2");
      end
   endgenerate

   logic             dec_valid;
   logic [IDX_W-1:0] dec_idx;
   logic             dec_eol;

   ctc_col_argmax #(
      .NUM_CLASSES(NUM_CLASSES),
      .SCORE_W    (SCORE_W),
      .IDX_W      (IDX_W)
   ) u_argmax (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (score_valid),
      .in_score (score),
      .in_last  (score_last),
      .in_eol   (line_end),
      .dec_valid(dec_valid),
      .dec_idx  (dec_idx),
      .dec_eol  (dec_eol)
   );

   ctc_collapse #(
      .NUM_CLASSES(NUM_CLASSES),
      .IDX_W      (IDX_W)
   ) u_collapse (
      .clk      (clk),
      .rst_n    (rst_n),
      .dec_valid(dec_valid),
      .dec_idx  (dec_idx),
      .dec_eol  (dec_eol),
      .out_valid(out_valid),
      .out_label(out_label),
      .line_done(line_done)
   );
endmodule

// File: rtl/ctc_greedy_decoder_chk.sv
module ctc_greedy_decoder_chk #(
   parameter int NUM_CLASSES = 110,
   localparam int IDX_W      = ctc_pkg::idx_width(NUM_CLASSES)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             score_valid,
   input logic             score_last,
   input logic             line_end,
   input logic             out_valid,
   input logic [IDX_W-1:0] out_label,
   input logic             line_done
);
   localparam logic [IDX_W-1:0] BLANK_IDX = IDX_W'(NUM_CLASSES - 1);

   logic [1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            age_q <= '0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
   end

   // R4
   no_blank_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_label != BLANK_IDX));

   // R2
   label_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_label < IDX_W'(NUM_CLASSES - 1)));

   // R9
   emit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n || age_q < 2'd2)
      out_valid |-> $past(score_valid && score_last, 2));

   // R9
   emit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R8
   done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n || age_q < 2'd2)
      line_done == $past(line_end, 2));
endmodule

bind ctc_greedy_decoder ctc_greedy_decoder_chk #(.NUM_CLASSES(NUM_CLASSES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .score_valid(score_valid),
   .score_last (score_last),
   .line_end   (line_end),
   .out_valid  (out_valid),
   .out_label  (out_label),
   .line_done  (line_done)
);

// File: tb/ctc_greedy_decoder_bench.sv
module ctc_greedy_decoder_bench;
   localparam int K   = 4;
   localparam int SW  = 4;
   localparam int IW  = 2;
   localparam int BLK = K - 1;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 score_valid = 1'b0;
   logic signed [SW-1:0] score = '0;
   logic                 score_last = 1'b0;
   logic                 line_end = 1'b0;
   logic                 out_valid;
   logic [IW-1:0]        out_label;
   logic                 line_done;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  finished = 1'b0;
   logic signed [SW-1:0] col [K];
   bit  m_live = 1'b0;
   int  m_prev = 0;
   logic [31:0] seed = 32'h1234_5678;

   always #10 clk = ~clk;

   ctc_greedy_decoder #(.NUM_CLASSES(K), .SCORE_W(SW)) u_ctc_greedy_decoder (
      .clk(clk), .rst_n(rst_n), .score_valid(score_valid), .score(score),
      .score_last(score_last), .line_end(line_end),
      .out_valid(out_valid), .out_label(out_label), .line_done(line_done));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // send col[], optional idle gap with a huge score, optional line end
   task automatic send_col(input bit eol, input bit gap, input string tag);
      int  win = 0;
      bit  emit;
      for (int i = 1; i < K; i++) if (col[i] > col[win]) win = i;
      emit = (win != BLK) && !(m_live && m_prev == win);
      for (int i = 0; i < K; i++) begin
         if (gap && i == 1) begin
            @(negedge clk);
            score_valid = 1'b0; score = SW'(7); score_last = 1'b1; line_end = 1'b0;
         end
         @(negedge clk);
         score_valid = 1'b1;
         score       = col[i];
         score_last  = (i == K - 1);
         line_end    = eol && (i == K - 1);
      end
      @(negedge clk);
      score_valid = 1'b0; score_last = 1'b0; line_end = 1'b0; score = '0;
      @(negedge clk);
      check(out_valid == emit, {tag, " out_valid"}, out_valid, emit);
      if (emit) check(out_label == IW'(win), {tag, " out_label"}, out_label, win);
      check(line_done == eol, {tag, " line_done R8"}, line_done, eol);
      if (win == BLK) m_live = 1'b0;
      else begin m_live = 1'b1; m_prev = win; end
      if (eol) m_live = 1'b0;
   endtask

   task automatic set4(input int a, input int b, input int c, input int d);
      col[0] = SW'(a); col[1] = SW'(b); col[2] = SW'(c); col[3] = SW'(d);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1
      check(out_valid == 1'b0, "R1 out_valid at reset", out_valid, 0);
      check(line_done == 1'b0, "R1 line_done at reset", line_done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0 && line_done == 1'b0, "R1 idle after reset", out_valid, 0);

      set4(1, 5, 2, 0);   send_col(0, 0, "R2 R7 first column");
      set4(1, 5, 2, 0);   send_col(0, 0, "R5 repeat suppressed");
      set4(0, 0, 0, 6);   send_col(0, 0, "R4 blank");
      set4(1, 5, 2, 0);   send_col(0, 0, "R6 after blank");
      set4(3, 3, 3, 3);   send_col(0, 0, "R3 all tied");
      set4(2, 1, 0, -1);  send_col(1, 0, "R8 repeat with line end");
      set4(2, 1, 0, -1);  send_col(0, 0, "R7 after line end");
      set4(-3, -1, -2, -4); send_col(0, 1, "R10 R2 gap negative");
      set4(-8, 4, 4, 4);  send_col(0, 0, "R3 tie at 1");
      set4(-8, 4, 4, 4);  send_col(0, 0, "R5 repeat tie");
      set4(7, -8, 7, 7);  send_col(0, 1, "R10 R3 gap tie at 0");

      // R8: end of line on its own
      @(negedge clk); line_end = 1'b1;
      @(negedge clk); line_end = 1'b0;
      check(line_done == 1'b0, "R8 no early done", line_done, 0);
      @(negedge clk);
      check(line_done == 1'b1, "R8 done pulse", line_done, 1);
      check(out_valid == 1'b0, "R8 no emit on bare line end", out_valid, 0);
      @(negedge clk);
      check(line_done == 1'b0, "R8 done one cycle", line_done, 0);
      m_live = 1'b0;

      // R2 R3 R5 R6: sweep with narrow score range to force ties and repeats
      for (int n = 0; n < 600; n++) begin
         bit eol, gap;
         for (int i = 0; i < K; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            col[i] = (n < 300) ? SW'(int'(seed[17:16]) - 2) : SW'(seed[19:16]);
         end
         seed = seed * 32'd1103515245 + 32'd12345;
         eol = (seed[20:18] == 3'd0);
         gap = (seed[23:21] == 3'd1);
         send_col(eol, gap, "R2 R5 R6 sweep");
      end
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end
endmodule